// File: doc/BRIEF.md
# Instruction Fetch Patch Trap Unit

This unit watches a processor's instruction fetch port and compares every valid fetch address against a table of programmable 32-bit trap addresses. Each entry has its own enable bit. When a valid fetch hits an enabled entry, the unit answers that fetch with a one-cycle bus-fault pulse. The exception handler that takes the fault can then redirect execution to replacement code kept elsewhere.

The table, the enable word and a sticky fault status word sit in a small register file. A plain 32-bit register port reads and writes it, with byte offsets and a combinational read. The status word records which entry caused the first unhandled trap and holds it until software clears it. It can be cleared in two ways: by writing zero to its flag bit, or by writing one to a separate clear alias.

Top module: `fetch_trap_unit`

## Requirements
- R1: Trap entry i (0 to 29) is a 32-bit register at byte offset 4*i (0x00 to 0x74). A write stores the full word and a read returns it.
- R2: The enable word at offset 0x78 holds one bit per entry, with bit i enabling entry i. Bits 31:30 read as zero whatever was written to them.
- R3: A cycle with fetch_valid high and fetch_addr equal to an enabled entry drives fetch_fault high in the following cycle, for exactly that one cycle. A matching address on a disabled entry, or with fetch_valid low, gives no fault.
- R4: A fault taken while the status flag is clear sets the status word at offset 0x7C to flag bit 0 = 1 and bits 5:1 = index of the matching entry. The other bits read zero.
- R5: When several enabled entries hold the fetched address, the lowest-numbered one is recorded.
- R6: While the flag is set, later hits still raise fetch_fault, but the recorded index does not change.
- R7: A write to offset 0x7C with bit 0 = 0 returns the whole status word to zero. A write there with bit 0 = 1 changes nothing; neither the flag nor the index can be set by software.
- R8: A write to offset 0xA8 with bit 0 = 1 returns the status word to zero. A write there with bit 0 = 0 has no effect. Offset 0xA8 reads as zero.
- R9: If a clearing write and a trap hit fall in the same cycle, the new hit is recorded: the flag stays set and the index becomes the new entry.
- R10: Reset clears all entries, all enables, the status word and fetch_fault. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| fetch_valid | input | 1 | Instruction fetch strobe |
| fetch_addr | input | 32 | Instruction fetch address |
| fetch_fault | output | 1 | Bus-fault response, one cycle after the fetch |

## Verification
A table of fetches drives the main function with several kinds of address:
- a hit on a low entry and a hit on the top entry, which confirm that the index is encoded correctly;
- an address held by a disabled entry, which separates the enable gating from the compare itself;
- an address held by two enabled entries, which exposes any error in the priority order;
- a zero address that matches the reset-valued entries, which shows that reset-zero entries never trap unless enabled.

Directed sequences then cover:
- back-to-back hits with the flag set, which separate "fault still raised" from "index frozen";
- both clear paths, each with its no-effect polarity;
- a clear and a hit in the same cycle;
- a matching address with the strobe low;
- readback of the top enable bits and of unmapped offsets.

// File: rtl/fetch_trap_unit.sv
module fetch_trap_unit #(
  parameter int N_ENTRIES = 30,
  parameter int ADDR_W    = 32,
  parameter int OFS_W     = 8,
  parameter logic [7:0] CLR_OFS = 8'hA8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [OFS_W-1:0]  reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_fault
);
  localparam int IDX_W  = $clog2(N_ENTRIES);
  localparam int WORD_W = OFS_W - 2;
  localparam logic [OFS_W-1:0] EN_OFS  = OFS_W'(4 * N_ENTRIES);
  localparam logic [OFS_W-1:0] STS_OFS = OFS_W'(4 * N_ENTRIES + 4);
  localparam logic [OFS_W-1:0] ALIAS_OFS = OFS_W'(CLR_OFS);

  logic [ADDR_W-1:0]    trap_addr [N_ENTRIES];
  logic [N_ENTRIES-1:0] trap_en;
  logic                 status_flag;
  logic [IDX_W-1:0]     status_idx;

  logic [WORD_W-1:0] word;
  logic              entry_sel;
  logic              hit_any;
  logic [IDX_W-1:0]  hit_idx;
  logic              clr_req;
  logic              capture;

  assign word      = reg_addr[OFS_W-1:2];
  assign entry_sel = (reg_addr[1:0] == 2'b00) && (int'(word) < N_ENTRIES);
  assign clr_req   = reg_wr && (((reg_addr == STS_OFS) && !reg_wdata[0]) ||
                                ((reg_addr == ALIAS_OFS) && reg_wdata[0]));
  assign capture   = fetch_valid && hit_any && (!status_flag || clr_req);

  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (trap_en[i] && (trap_addr[i] == fetch_addr)) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (entry_sel)
      reg_rdata = 32'(trap_addr[word]);
    else if (reg_addr == EN_OFS)
      reg_rdata[N_ENTRIES-1:0] = trap_en;
    else if (reg_addr == STS_OFS)
      reg_rdata[IDX_W:0] = {status_idx, status_flag};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENTRIES; i++) trap_addr[i] <= '0;
      trap_en     <= '0;
      status_flag <= 1'b0;
      status_idx  <= '0;
      fetch_fault <= 1'b0;
    end else begin
      if (reg_wr && entry_sel) trap_addr[word] <= reg_wdata[ADDR_W-1:0];
      if (reg_wr && (reg_addr == EN_OFS)) trap_en <= reg_wdata[N_ENTRIES-1:0];
      fetch_fault <= fetch_valid && hit_any;
      if (capture) begin
        status_flag <= 1'b1;
        status_idx  <= hit_idx;
      end else if (clr_req) begin
        status_flag <= 1'b0;
        status_idx  <= '0;
      end
    end
  end
endmodule

// File: rtl/fetch_trap_checker.sv
module fetch_trap_checker #(
  parameter int N_ENTRIES = 30,
  parameter int OFS_W = 8,
  parameter int IDX_W = 5,
  parameter logic [7:0] CLR_OFS = 8'hA8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [OFS_W-1:0] reg_addr,
  input logic [31:0]      reg_wdata,
  input logic [31:0]      reg_rdata,
  input logic             fetch_valid,
  input logic             fetch_fault,
  input logic             status_flag,
  input logic [IDX_W-1:0] status_idx
);
  localparam logic [OFS_W-1:0] EN_OFS  = OFS_W'(4 * N_ENTRIES);
  localparam logic [OFS_W-1:0] STS_OFS = OFS_W'(4 * N_ENTRIES + 4);
  localparam logic [OFS_W-1:0] ALIAS_OFS = OFS_W'(CLR_OFS);

  logic clr_wr;
  assign clr_wr = reg_wr && (((reg_addr == STS_OFS) && !reg_wdata[0]) ||
                             ((reg_addr == ALIAS_OFS) && reg_wdata[0]));

  a_r3_fault_needs_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_fault |-> $past(fetch_valid));
  a_r3_no_fetch_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> !fetch_fault);
  a_r4_fault_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_fault |-> status_flag);
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status_flag && !clr_wr) |=> status_flag);
  a_r6_index_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (status_flag && !clr_wr) |=> $stable(status_idx));
  a_r7_clear_without_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !fetch_valid) |=> !status_flag);
  a_r2_enable_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == EN_OFS) |-> (reg_rdata[31:N_ENTRIES] == '0));
  a_r8_alias_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ALIAS_OFS) |-> (reg_rdata == 32'h0));
endmodule

bind fetch_trap_unit fetch_trap_checker #(
  .N_ENTRIES(N_ENTRIES), .OFS_W(OFS_W), .IDX_W(IDX_W), .CLR_OFS(CLR_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_valid(fetch_valid),
  .fetch_fault(fetch_fault), .status_flag(status_flag), .status_idx(status_idx)
);

// File: tb/fetch_trap_unit_test.sv
`timescale 1ns/1ps
module fetch_trap_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = 32'h0;
  logic        fetch_fault;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  fetch_trap_unit uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .fetch_fault(fetch_fault)
  );

  localparam logic [7:0] EN = 8'h78, STS = 8'h7C, ALIAS = 8'hA8;

  // {fetch address, expected fault, expected status word}
  localparam logic [64:0] VEC [6] = '{
    {32'h0000_4100, 1'b1, 32'h0000_0007},   // entry 3
    {32'hFFFF_FFFC, 1'b1, 32'h0000_003B},   // entry 29
    {32'h0000_5500, 1'b0, 32'h0000_0000},   // entry 5, disabled
    {32'hDEAD_BEE0, 1'b1, 32'h0000_0019},   // entries 12 and 20, lowest wins
    {32'h1234_5678, 1'b1, 32'h0000_000F},   // entry 7
    {32'h0000_0000, 1'b0, 32'h0000_0000}    // reset-valued entries, disabled
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic fetch(input logic [31:0] a, input logic exp, input string tag);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = a;
    @(negedge clk);
    fetch_valid = 1'b0;
    chk(tag, 32'(fetch_fault), 32'(exp));
    @(negedge clk);
    chk({tag, " single cycle"}, 32'(fetch_fault), 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    chk("R10 fault after reset", 32'(fetch_fault), 32'h0);
    rd(STS, v);   chk("R10 status after reset", v, 32'h0);
    rd(EN, v);    chk("R10 enable after reset", v, 32'h0);
    rd(8'h2C, v); chk("R10 entry 11 after reset", v, 32'h0);
    rd(8'h80, v); chk("R10 unmapped reads zero", v, 32'h0);

    // R1 / R2: register file
    wr(8'h0C, 32'h0000_4100);
    wr(8'h14, 32'h0000_5500);
    wr(8'h1C, 32'h1234_5678);
    wr(8'h30, 32'hDEAD_BEE0);
    wr(8'h50, 32'hDEAD_BEE0);
    wr(8'h74, 32'hFFFF_FFFC);
    rd(8'h1C, v); chk("R1 entry 7 readback", v, 32'h1234_5678);
    rd(8'h74, v); chk("R1 entry 29 readback", v, 32'hFFFF_FFFC);
    wr(EN, 32'hFFFF_FFFF);
    rd(EN, v);    chk("R2 enable top bits zero", v, 32'h3FFF_FFFF);
    wr(EN, 32'h2010_1088);
    rd(EN, v);    chk("R2 enable readback", v, 32'h2010_1088);
    rd(ALIAS, v); chk("R8 alias reads zero", v, 32'h0);

    // R3 R4 R5: table walk
    foreach (VEC[k]) begin
      fetch(VEC[k][64:33], VEC[k][32], $sformatf("R3 vector %0d fault", k));
      rd(STS, v);
      chk($sformatf("R4 R5 vector %0d status", k), v, VEC[k][31:0]);
      wr(ALIAS, 32'h1);
      rd(STS, v);
      chk($sformatf("R8 vector %0d cleared", k), v, 32'h0);
    end

    // R3: match with strobe low
    @(negedge clk);
    fetch_addr = 32'h0000_4100;
    @(negedge clk);
    chk("R3 strobe low no fault", 32'(fetch_fault), 32'h0);
    rd(STS, v); chk("R3 strobe low no status", v, 32'h0);

    // R6: sticky index
    fetch(32'h0000_4100, 1'b1, "R6 first hit");
    fetch(32'h1234_5678, 1'b1, "R6 second hit still faults");
    rd(STS, v); chk("R6 index kept", v, 32'h0000_0007);

    // R7: clear through status word
    wr(STS, 32'hFFFF_FFFF);
    rd(STS, v); chk("R7 write one no effect", v, 32'h0000_0007);
    wr(STS, 32'h0000_0000);
    rd(STS, v); chk("R7 write zero clears", v, 32'h0);
    wr(STS, 32'h0000_003F);
    rd(STS, v); chk("R7 cannot set by software", v, 32'h0);

    // R8: alias polarity
    fetch(32'hFFFF_FFFC, 1'b1, "R8 setup hit");
    wr(ALIAS, 32'h0);
    rd(STS, v); chk("R8 alias zero no effect", v, 32'h0000_003B);

    // R9: clear and hit together
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ALIAS; reg_wdata = 32'h1;
    fetch_valid = 1'b1; fetch_addr = 32'h1234_5678;
    @(negedge clk);
    reg_wr = 1'b0; fetch_valid = 1'b0;
    chk("R9 fault on same-cycle hit", 32'(fetch_fault), 32'h1);
    rd(STS, v); chk("R9 new hit recorded", v, 32'h0000_000F);

    // R10: reset mid-operation
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd(STS, v);   chk("R10 status after re-reset", v, 32'h0);
    rd(EN, v);    chk("R10 enable after re-reset", v, 32'h0);
    rd(8'h1C, v); chk("R10 entry 7 after re-reset", v, 32'h0);
    fetch(32'h1234_5678, 1'b0, "R10 no fault after re-reset");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule